// File: doc/BRIEF.md
# External Peripheral Register Bus Bridge

This block sits between a processor core and a small set of user-defined registers outside the chip, such as converter data latches. The core hands it a request holding a register index, a direction and, for writes, a data word. The bridge puts the index on a 3-bit address output and sets the bus direction. It pulls a write strobe low for the access and holds every pin steady for as long as the peripheral keeps its ready input inactive. When it sees ready active at a rising clock edge, it ends the access. For reads it captures the input data bus at that same edge, and it then reports completion to the core.

The request side uses a valid/ready handshake. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in progress, so the core must hold its request until it is taken. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the core must take when it appears. `busy` is a plain stall signal that stays high for the whole access, including every wait state. The bidirectional data bus is modelled as separate output, input and output-enable signals. By default the bus drives outward, and it turns to input only for the duration of a read.

Top module: `xbus_bridge`

## Requirements
- R1: After reset, `pb_stb_n`=1, `pb_dir_n`=0, `pb_oe`=1, `busy`=0, `req_ready`=1, `rsp_valid`=0 and `pb_addr`=0.
- R2: In the cycle after a request is accepted, `pb_stb_n`=0, `busy`=1 and `pb_addr` equals the request index. A write (`req_write`=1) drives `req_wdata` on `pb_dout` with `pb_dir_n`=0 and `pb_oe`=1. A read (`req_write`=0) gives `pb_dir_n`=1 and `pb_oe`=0.
- R3: While `pb_stb_n` is low and `pb_rdy_n` is sampled high (inactive) at a rising edge, `pb_stb_n`, `pb_addr`, `pb_dout`, `pb_dir_n` and `pb_oe` are unchanged in the next cycle.
- R4: When `pb_rdy_n` is sampled low at a rising edge while `pb_stb_n` is low, the next cycle has `pb_stb_n`=1 and `busy`=0, so the peripheral sees a strobe rising edge. With no wait states, the strobe is low for exactly one cycle.
- R5: On a read, `rsp_rdata` takes the value on `pb_din` at the completing edge. A write completion leaves `rsp_rdata` unchanged.
- R6: When no access is in progress, the bus drives outward (`pb_dir_n`=0, `pb_oe`=1), `pb_stb_n` is high and `pb_addr` keeps the index of the last access.
- R7: `req_ready` is low whenever `busy` is high. A request presented then is not taken: the address and the direction of the ongoing access are unaffected, and no extra access follows.
- R8: `rsp_valid` is high for exactly one cycle per access, in the cycle after the completing edge. Responses come in request order.
- R9: Wait states have no upper limit: with N inactive ready samples the strobe stays low for N+1 cycles.
- R10: `pb_oe` is always the complement of `pb_dir_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Bridge can take a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | External register index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data captured by the last read |
| busy | output | 1 | Stall for the core while an access is open |
| pb_addr | output | 3 | External register address pins |
| pb_dout | output | 16 | Data bus output value |
| pb_din | input | 16 | Data bus input value |
| pb_oe | output | 1 | Data bus output enable |
| pb_dir_n | output | 1 | Direction, low = bridge drives |
| pb_stb_n | output | 1 | Access strobe; writes latch on its rising edge |
| pb_rdy_n | input | 1 | Peripheral ready, active low |

## Verification
A sequencer stuck in its access state shows up at once as `busy` stuck high and `req_ready` stuck low. The next request then never starts, and the response scoreboard misses an item. A stale direction register leaves `pb_dir_n` high after a read. This appears in the first idle cycle, and the peripheral model then sees a write strobe with no driven data, which corrupts a later read-back. A wrong capture edge or a wait count that is off by one shows within one cycle of completion, either as wrong read data or as a strobe-low length different from the number of wait states plus one.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic {
    XB_IDLE = 1'b0,
    XB_OPEN = 1'b1
  } xb_state_e;

  // Direction encoding used on the bus pins
  localparam logic XB_DRIVE  = 1'b0;
  localparam logic XB_LISTEN = 1'b1;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy_n,
  output logic stb_n,
  output logic busy,
  output logic idle,
  output logic finish
);
  xb_state_e state;
  logic      stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XB_IDLE;
      stb_q <= 1'b1;
    end else begin
      unique case (state)
        XB_IDLE: if (start) begin
          state <= XB_OPEN;
          stb_q <= 1'b0;
        end
        XB_OPEN: if (!rdy_n) begin
          state <= XB_IDLE;
          stb_q <= 1'b1;
        end
        default: state <= XB_IDLE;
      endcase
    end
  end

  assign stb_n  = stb_q;
  assign busy   = (state == XB_OPEN);
  assign idle   = (state == XB_IDLE);
  assign finish = (state == XB_OPEN) && !rdy_n;

  AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_q && rdy_n) |=> !stb_q); // R3
endmodule

// File: rtl/xbus_pin_hold.sv
module xbus_pin_hold
  import xbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              finish,
  input  logic              wr,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dir_n,
  output logic              oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      dout  <= '0;
      dir_n <= XB_DRIVE;
      oe    <= 1'b1;
    end else if (load) begin
      addr <= idx;
      if (wr) begin
        dout  <= wdata;
        dir_n <= XB_DRIVE;
        oe    <= 1'b1;
      end else begin
        dir_n <= XB_LISTEN;
        oe    <= 1'b0;
      end
    end else if (finish) begin
      dir_n <= XB_DRIVE;
      oe    <= 1'b1;
    end
  end

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    oe != dir_n); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr)); // R6
endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture
  import xbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finish,
  input  logic              dir_n,
  input  logic [DATA_W-1:0] din,
  output logic              valid,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rdata <= '0;
    end else begin
      valid <= finish;
      if (finish && dir_n == XB_LISTEN) rdata <= din;
    end
  end

  AST_RDATA_ON_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(finish && dir_n == XB_LISTEN) |=> $stable(rdata)); // R5
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge #(
  parameter  int DATA_W   = 16,
  parameter  int NUM_REGS = 8,
  localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [DATA_W-1:0] pb_dout,
  input  logic [DATA_W-1:0] pb_din,
  output logic              pb_oe,
  output logic              pb_dir_n,
  output logic              pb_stb_n,
  input  logic              pb_rdy_n
);
  logic idle, finish, start;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  xbus_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rdy_n  (pb_rdy_n),
    .stb_n  (pb_stb_n),
    .busy   (busy),
    .idle   (idle),
    .finish (finish)
  );

  xbus_pin_hold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .finish (finish),
    .wr     (req_write),
    .idx    (req_idx),
    .wdata  (req_wdata),
    .addr   (pb_addr),
    .dout   (pb_dout),
    .dir_n  (pb_dir_n),
    .oe     (pb_oe)
  );

  xbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .finish (finish),
    .dir_n  (pb_dir_n),
    .din    (pb_din),
    .valid  (rsp_valid),
    .rdata  (rsp_rdata)
  );

  AST_START_DRIVES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!pb_stb_n && busy && pb_addr == $past(req_idx))); // R2
  AST_WAIT_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_stb_n && pb_rdy_n) |=> ($stable(pb_addr) && $stable(pb_dout) && $stable(pb_dir_n))); // R3
  AST_READY_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_stb_n && !pb_rdy_n) |=> (pb_stb_n && rsp_valid && !busy)); // R4
  AST_IDLE_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    pb_stb_n |-> (!pb_dir_n && pb_oe)); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/xbus_bridge_bench.sv
`timescale 1ns/1ps
module xbus_bridge_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, rsp_valid, busy;
  logic [2:0]  req_idx, pb_addr;
  logic [15:0] req_wdata, rsp_rdata, pb_dout, pb_din;
  logic        pb_oe, pb_dir_n, pb_stb_n, pb_rdy_n;

  xbus_bridge u_xbus_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .pb_addr(pb_addr), .pb_dout(pb_dout), .pb_din(pb_din), .pb_oe(pb_oe),
    .pb_dir_n(pb_dir_n), .pb_stb_n(pb_stb_n), .pb_rdy_n(pb_rdy_n)
  );

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Peripheral model: eight registers, writes latched on strobe rising edge
  logic [15:0] preg [8];
  initial for (int i = 0; i < 8; i++) preg[i] = 16'hA000 + 16'(i) * 16'h0111;
  assign pb_din = pb_dir_n ? preg[pb_addr] : 16'h0000;
  always @(posedge pb_stb_n) if (rst_n === 1'b1 && pb_dir_n === 1'b0) preg[pb_addr] <= pb_dout;

  // Ready model: N inactive samples before the active one
  int waits_cfg = 0, wcnt = 0;
  initial pb_rdy_n = 1'b1;
  always @(negedge clk) begin
    if (pb_stb_n !== 1'b0) begin
      wcnt = 0;
      pb_rdy_n <= 1'b1;
    end else begin
      pb_rdy_n <= (wcnt < waits_cfg);
      wcnt++;
    end
  end

  // Scoreboard
  typedef struct { bit wr; logic [15:0] data; } exp_t;
  exp_t sbq[$];
  logic [15:0] exp_regs [8];
  logic [15:0] last_rd = 16'h0000;
  initial for (int i = 0; i < 8; i++) exp_regs[i] = 16'hA000 + 16'(i) * 16'h0111;

  task automatic push_exp(input bit wr, input int idx, input logic [15:0] d);
    exp_t e;
    e.wr = wr;
    if (wr) begin
      exp_regs[idx] = d;
      e.data = last_rd;
    end else begin
      last_rd = exp_regs[idx];
      e.data = last_rd;
    end
    sbq.push_back(e);
  endtask

  logic prev_rsp = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rsp_valid === 1'b1) begin
        chk(prev_rsp == 1'b0, "R8 single-cycle pulse", 32'(prev_rsp), 0);
        if (sbq.size() == 0) chk(1'b0, "R8 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(rsp_rdata == e.data, e.wr ? "R5 rdata held on write" : "R5 read data", 32'(rsp_rdata), 32'(e.data));
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  // Driver
  task automatic access(input bit wr, input int idx, input logic [15:0] d, input int waits);
    int low;
    waits_cfg = waits;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_idx = 3'(idx); req_wdata = d;
    while (req_ready !== 1'b1) @(negedge clk);
    push_exp(wr, idx, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(pb_stb_n == 1'b0 && busy == 1'b1, "R2 strobe low and busy", {pb_stb_n, busy}, 2'b01);
    chk(pb_addr == 3'(idx), "R2 address", 32'(pb_addr), 32'(idx));
    if (wr) chk(pb_dout == d && !pb_dir_n && pb_oe, "R2 write drive", {pb_dout, pb_dir_n, pb_oe}, {d, 2'b01});
    else    chk(pb_dir_n && !pb_oe, "R2 read turnaround", {pb_dir_n, pb_oe}, 2'b10);
    low = 1;
    while (pb_stb_n == 1'b0) begin
      @(negedge clk);
      if (pb_stb_n == 1'b0) begin
        low++;
        chk(pb_addr == 3'(idx) && pb_dir_n == !wr, "R3 pins held in wait", {pb_addr, pb_dir_n}, {3'(idx), !wr});
        if (wr) chk(pb_dout == d, "R3 data held in wait", 32'(pb_dout), 32'(d));
      end
    end
    chk(low == waits + 1, waits > 3 ? "R9 long wait length" : "R4 strobe low length", low, waits + 1);
    chk(busy == 1'b0 && rsp_valid == 1'b1, "R4 completion", {busy, rsp_valid}, 2'b01);
    chk(!pb_dir_n && pb_oe && pb_addr == 3'(idx), "R6 idle drive and address hold",
        {pb_dir_n, pb_oe, pb_addr}, {2'b01, 3'(idx)});
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_idx = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pb_stb_n && !pb_dir_n && pb_oe && !busy && req_ready && !rsp_valid && pb_addr == 0,
        "R1 reset state", {pb_stb_n, pb_dir_n, pb_oe, busy, req_ready, rsp_valid, pb_addr},
        {6'b101010, 3'b000});

    access(1'b1, 3, 16'h1234, 0);
    access(1'b0, 3, 16'h0000, 0);
    access(1'b0, 5, 16'h0000, 3);
    access(1'b1, 0, 16'hBEEF, 40);
    access(1'b0, 0, 16'h0000, 1);

    // R7: request offered while busy must be ignored
    waits_cfg = 8;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_idx = 3'd2;
    push_exp(1'b0, 2, 16'h0000);
    @(negedge clk);
    req_write = 1'b1; req_idx = 3'd7; req_wdata = 16'h5555;
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0 && busy == 1'b1, "R7 not ready while busy", {req_ready, busy}, 2'b01);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (pb_stb_n == 1'b0) @(negedge clk);
    chk(pb_addr == 3'd2 && !pb_dir_n, "R7 ongoing access unaffected", {pb_addr, pb_dir_n}, {3'd2, 1'b0});
    @(negedge clk);
    chk(pb_stb_n == 1'b1 && busy == 1'b0, "R7 no extra access", {pb_stb_n, busy}, 2'b10);
    access(1'b0, 7, 16'h0000, 0);

    for (int i = 0; i < 8; i++) access(1'b1, i, 16'h1357 ^ (16'(i) << 4), i % 3);
    for (int i = 7; i >= 0; i--) access(1'b0, i, 16'h0000, (i * 5) % 4);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R8 all responses seen", sbq.size(), 0);
    chk(pb_oe == !pb_dir_n, "R10 enable complements direction", {pb_oe, pb_dir_n}, 2'b10);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule